// File: doc/BRIEF.md
# Nine-Bit Serial Transceiver with Selectable Parity

This block is an asynchronous serial transmitter and receiver. Its long frame has a start bit, eight data bits sent least significant bit first, a ninth bit and one stop bit at logic 1. A parity-enable input decides what the ninth bit means. With parity enabled, the transmitter computes the ninth bit from the data byte. The receiver compares the received ninth bit against the parity it expects and reports a mismatch on a parity-error flag. With parity disabled, the ninth bit is plain data. The transmitter sends the software bit `tx_sel`, and the receiver stores the received ninth bit in the `rx_sel` register.

The two selector bits have two roles. With parity enabled, `tx_sel` selects even (0) or odd (1) parity for transmit, and `rx_sel` selects even (0) or odd (1) checking for receive. With parity disabled, the same bits carry the ninth data bit.

Any `frame_mode` other than the nine-bit code sends and receives a short frame: start bit, eight data bits, stop bit. In a short frame, parity is off whatever `par_en` says.

Timing comes from an external `baud_tick` strobe at 16 times the bit rate.

Transmit bytes enter on a valid/ready stream. A byte is accepted on a clock edge where both `tx_valid` and `tx_ready` are high. `tx_ready` stays low until the whole frame, including the stop bit, has left the line.

The receive side cannot apply back-pressure to the serial line. `rx_valid` stays high until a cycle with `rx_ready` high. If a new frame completes before that, it replaces the held byte.

Top module: `nine_bit_uart`

## Requirements
- R1: After reset, `rx_data` is 8'hFF, `rx_valid` is 0, `tx_ready` is 1, `tx_busy` is 0, `txd` is 1, `rx_perr` is 0 and `rx_sel` is 0.
- R2: The line carries a 0 start bit, then the data byte least significant bit first. When `frame_mode` is 2'b10, the ninth bit follows. Then comes a 1 stop bit, and the line idles at 1. Every bit lasts 16 `baud_tick` pulses.
- R3: With `frame_mode`=2'b10 and `par_en`=1, the transmitted ninth bit makes the count of ones in data plus ninth bit even when `tx_sel`=0 and odd when `tx_sel`=1.
- R4: With `frame_mode`=2'b10 and `par_en`=0, the transmitted ninth bit equals `tx_sel`.
- R5: The receiver reassembles the byte least significant bit first and samples each bit at mid-bit. It presents the byte on `rx_data` with `rx_valid`=1 once the stop bit has been sampled.
- R6: With `frame_mode`=2'b10 and `par_en`=1, `rx_perr` is rewritten when the ninth bit is sampled. It becomes 1 exactly when the ones in data plus ninth bit do not match the parity chosen by `rx_sel` (0 even, 1 odd).
- R7: When parity is inactive (short frame, or `par_en`=0), a received frame clears `rx_perr`. A short frame never sends a ninth bit and leaves `rx_sel` unchanged.
- R8: With `frame_mode`=2'b10 and `par_en`=0, `rx_sel` takes the received ninth bit. With `par_en`=1, a received frame does not change `rx_sel`.
- R9: A low pulse on `rxd` that is high again by mid-bit of the start bit produces no received byte.
- R10: `tx_ready` is 0 and `tx_busy` is 1 while a frame is being sent. `rx_valid` drops one cycle after a cycle with `rx_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe at 16x bit rate |
| frame_mode | input | 2 | 2'b10 selects the nine-bit frame; other codes select the short frame |
| par_en | input | 1 | Parity enable (only effective in nine-bit frame) |
| tx_sel | input | 1 | Transmit parity select, or ninth transmit data bit |
| rx_sel_we | input | 1 | Software write strobe for `rx_sel` |
| rx_sel_wdata | input | 1 | Value written into `rx_sel` |
| rx_sel | output | 1 | Receive parity select, or received ninth data bit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_busy | output | 1 | A frame is being sent |
| rx_valid | output | 1 | Received byte held |
| rx_data | output | 8 | Received byte (resets to FFh) |
| rx_ready | input | 1 | Consumer takes the held byte |
| rx_perr | output | 1 | Receive parity error flag |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
The transmitter is tried with bytes of even and of odd weight, under both parity selections and with parity disabled. The chosen byte/selector pairs make generated parity and a copied `tx_sel` give different ninth bits, which separates R3 from R4. The short frame is sent with `par_en`=1, so a leaked parity bit would show up where the stop bit should be. On receive, frames carry matching and mismatching ninth bits under even and odd selection and under plain-data mode. A short frame that follows a parity error shows whether the flag is cleared. A short low glitch checks that false starts are rejected.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam logic [1:0] MODE_NINE = 2'b10;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  // ninth bit that gives even (odd_sel=0) or odd (odd_sel=1) total weight
  function automatic logic ninth_parity(input logic [7:0] d, input logic odd_sel);
    return (^d) ^ odd_sel;
  endfunction
endpackage

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine,
  input  logic              ninth_bit,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int BL_W    = $clog2(FRAME_W + 1);
  localparam int SUB_W   = $clog2(OSR);

  logic [FRAME_W-1:0] shreg;
  logic [BL_W-1:0]    bits_left;
  logic [SUB_W-1:0]   sub;
  logic               busy;

  assign busy     = (bits_left != '0);
  assign in_ready = !busy;
  assign txd      = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '1;
      bits_left <= '0;
      sub       <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        shreg     <= nine ? {1'b1, ninth_bit, in_data, 1'b0}
                          : {2'b11, in_data, 1'b0};
        bits_left <= nine ? BL_W'(DATA_W + 3) : BL_W'(DATA_W + 2);
        sub       <= '0;
      end
    end else if (tick) begin
      if (sub == SUB_W'(OSR - 1)) begin
        sub       <= '0;
        shreg     <= {1'b1, shreg[FRAME_W-1:1]};
        bits_left <= bits_left - 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R2
  AST_TX_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> $stable(txd)); // R2
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              nine,
  input  logic              par_en,
  input  logic              par_odd,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              perr,
  output logic              ninth_we,
  output logic              ninth_bit
);
  localparam int SUB_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [SUB_W-1:0] MID  = SUB_W'(OSR / 2 - 1);
  localparam logic [SUB_W-1:0] LAST = SUB_W'(OSR - 1);

  rx_state_t         state;
  logic              rx_meta, rx_s;
  logic [SUB_W-1:0]  sub;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              nine_q, pen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rxd;
      rx_s    <= rx_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      sub       <= '0;
      idx       <= '0;
      shreg     <= '0;
      nine_q    <= 1'b0;
      pen_q     <= 1'b0;
      out_data  <= '1;
      out_valid <= 1'b0;
      perr      <= 1'b0;
      ninth_we  <= 1'b0;
      ninth_bit <= 1'b0;
    end else begin
      ninth_we <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: if (!rx_s) begin
            state  <= RX_START;
            sub    <= '0;
            nine_q <= nine;
            pen_q  <= nine && par_en;
          end
          RX_START: if (sub == MID) begin
            sub   <= '0;
            idx   <= '0;
            state <= rx_s ? RX_IDLE : RX_DATA;
          end else sub <= sub + 1'b1;
          RX_DATA: if (sub == LAST) begin
            sub <= '0;
            idx <= idx + 1'b1;
            if (idx < IDX_W'(DATA_W)) begin
              shreg <= {rx_s, shreg[DATA_W-1:1]};
              if (idx == IDX_W'(DATA_W - 1) && !nine_q) state <= RX_STOP;
            end else begin
              state <= RX_STOP;
              if (pen_q) perr <= (^shreg) ^ rx_s ^ par_odd;
              else begin
                perr      <= 1'b0;
                ninth_we  <= 1'b1;
                ninth_bit <= rx_s;
              end
            end
          end else sub <= sub + 1'b1;
          RX_STOP: if (sub == LAST) begin
            sub       <= '0;
            state     <= RX_IDLE;
            out_data  <= shreg;
            out_valid <= 1'b1;
            if (!nine_q) perr <= 1'b0;
          end else sub <= sub + 1'b1;
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_VALID_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(state) == RX_STOP); // R5
  AST_SHORT_NO_PERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && !nine_q |-> !perr); // R7
  AST_PERR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(perr)); // R6
  AST_NINTH_PLAIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ninth_we |-> nine_q && !pen_q); // R8
endmodule

// File: rtl/nine_bit_uart.sv
module nine_bit_uart
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [1:0]        frame_mode,
  input  logic              par_en,
  input  logic              tx_sel,
  input  logic              rx_sel_we,
  input  logic              rx_sel_wdata,
  output logic              rx_sel,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              tx_busy,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              rx_perr,
  output logic              txd,
  input  logic              rxd
);
  logic nine_mode, tx_ninth, rx_ninth_we, rx_ninth;

  assign nine_mode = (frame_mode == MODE_NINE);
  assign tx_ninth  = (nine_mode && par_en) ? ninth_parity(tx_data, tx_sel) : tx_sel;
  assign tx_busy   = !tx_ready;

  uart9_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .nine(nine_mode),
    .ninth_bit(tx_ninth), .in_valid(tx_valid), .in_data(tx_data),
    .in_ready(tx_ready), .txd(txd)
  );

  uart9_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd), .nine(nine_mode),
    .par_en(par_en), .par_odd(rx_sel), .out_data(rx_data), .out_valid(rx_valid),
    .out_ready(rx_ready), .perr(rx_perr), .ninth_we(rx_ninth_we),
    .ninth_bit(rx_ninth)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rx_sel <= 1'b0;
    else if (rx_sel_we)   rx_sel <= rx_sel_wdata;
    else if (rx_ninth_we) rx_sel <= rx_ninth;
  end

  AST_SEL_KEPT_WITH_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    par_en && !rx_sel_we && $past(par_en) |=> $stable(rx_sel)); // R8
endmodule

// File: tb/test_nine_bit_uart.sv
module test_nine_bit_uart;
  logic clk = 0, rst_n = 0, baud_tick = 0;
  logic [1:0] frame_mode = 2'b10;
  logic par_en = 0, tx_sel = 0, rx_sel_we = 0, rx_sel_wdata = 0;
  logic rx_sel, tx_valid = 0, tx_ready, tx_busy, rx_valid, rx_ready = 0, rx_perr, txd;
  logic rxd = 1;
  logic [7:0] tx_data = 0, rx_data;
  int total = 0, bad = 0;
  int tcnt = 0;

  always #5 clk = ~clk;
  always @(posedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == 3);
  end

  nine_bit_uart i_nine_bit_uart (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_tx(input logic [7:0] d, input int nbits, output logic [10:0] bits);
    @(negedge clk); tx_data = d; tx_valid = 1;
    @(negedge clk); tx_valid = 0;
    wait (txd == 0);
    repeat (32) @(negedge clk);
    bits = '1;
    for (int i = 0; i < nbits; i++) begin
      bits[i] = txd;
      if (i == 4) check("R10 tx_busy mid-frame", tx_busy, 1);
      repeat (64) @(negedge clk);
    end
  endtask

  task automatic drive_rx(input logic [10:0] bits, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); rxd = bits[i];
      repeat (63) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic take_rx();
    @(negedge clk); rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  task automatic t_reset();
    check("R1 rx_data", rx_data, 8'hFF);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 tx_busy", tx_busy, 0);
    check("R1 txd", txd, 1);
    check("R1 rx_perr", rx_perr, 0);
    check("R1 rx_sel", rx_sel, 0);
  endtask

  task automatic t_tx_parity();
    logic [10:0] b;
    frame_mode = 2'b10; par_en = 1; tx_sel = 0;
    send_tx(8'h35, 11, b);
    check("R2 frame 35", b, {1'b1, 1'b0, 8'h35, 1'b0});
    check("R3 even ninth 35", b[9], 0);
    send_tx(8'h07, 11, b);
    check("R3 even ninth 07", b[9], 1);
    tx_sel = 1;
    send_tx(8'h07, 11, b);
    check("R3 odd ninth 07", b[9], 0);
    check("R2 data LSB first", b[8:1], 8'h07);
  endtask

  task automatic t_tx_plain();
    logic [10:0] b;
    frame_mode = 2'b10; par_en = 0; tx_sel = 1;
    send_tx(8'h01, 11, b);
    check("R4 ninth=tx_sel 1", b[9], 1);
    tx_sel = 0;
    send_tx(8'h01, 11, b);
    check("R4 ninth=tx_sel 0", b[9], 0);
  endtask

  task automatic t_tx_short();
    logic [10:0] b;
    frame_mode = 2'b01; par_en = 1; tx_sel = 0;
    send_tx(8'hA5, 10, b);
    check("R7 short frame no ninth", b[9:0], {1'b1, 8'hA5, 1'b0});
    check("R10 tx_ready after frame", tx_ready, 1);
  endtask

  task automatic t_rx_parity();
    frame_mode = 2'b10; par_en = 1;
    drive_rx({1'b1, 1'b0, 8'h35, 1'b0}, 11);
    check("R5 rx_valid", rx_valid, 1);
    check("R5 rx_data", rx_data, 8'h35);
    check("R6 even ok", rx_perr, 0);
    take_rx();
    check("R10 rx_valid cleared", rx_valid, 0);
    drive_rx({1'b1, 1'b1, 8'h35, 1'b0}, 11);
    check("R6 even mismatch", rx_perr, 1);
    check("R8 rx_sel kept", rx_sel, 0);
    take_rx();
    @(negedge clk); rx_sel_we = 1; rx_sel_wdata = 1;
    @(negedge clk); rx_sel_we = 0;
    drive_rx({1'b1, 1'b0, 8'h07, 1'b0}, 11);
    check("R6 odd ok", rx_perr, 0);
    check("R8 rx_sel kept odd", rx_sel, 1);
    take_rx();
    drive_rx({1'b1, 1'b1, 8'h07, 1'b0}, 11);
    check("R6 odd mismatch", rx_perr, 1);
    take_rx();
  endtask

  task automatic t_rx_short();
    frame_mode = 2'b00; par_en = 1;
    drive_rx({2'b11, 8'hC3, 1'b0}, 10);
    check("R5 short rx_data", rx_data, 8'hC3);
    check("R7 perr cleared", rx_perr, 0);
    check("R7 rx_sel unchanged", rx_sel, 1);
    take_rx();
  endtask

  task automatic t_rx_plain();
    frame_mode = 2'b10; par_en = 0;
    drive_rx({1'b1, 1'b0, 8'h5A, 1'b0}, 11);
    check("R8 rx_sel=0", rx_sel, 0);
    check("R7 plain perr 0", rx_perr, 0);
    take_rx();
    drive_rx({1'b1, 1'b1, 8'h5A, 1'b0}, 11);
    check("R8 rx_sel=1", rx_sel, 1);
    check("R5 plain rx_data", rx_data, 8'h5A);
    take_rx();
  endtask

  task automatic t_false_start();
    @(negedge clk); rxd = 0;
    repeat (16) @(negedge clk); rxd = 1;
    repeat (1000) @(negedge clk);
    check("R9 glitch ignored", rx_valid, 0);
    check("R9 data unchanged", rx_data, 8'h5A);
  endtask

  initial begin
    #200ms;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_tx_parity();
    t_tx_plain();
    t_tx_short();
    t_rx_parity();
    t_rx_short();
    t_rx_plain();
    t_false_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule